// File: doc/BRIEF.md
# Adaptive Detector Selection Controller

This controller sits in front of two MIMO detector engines: a low-cost zero-forcing successive-cancellation detector and a fixed-complexity sphere decoder. At every frame start it reads a channel-capacity metric that is computed elsewhere. It compares the metric with two preset thresholds. From that comparison it either sends the frame to one of the two detectors or gives up on the frame and asks for a retransmission. The threshold for zero-forcing is the upper one (`thr_zf`). The threshold for the sphere decoder is the lower one (`thr_sd`), and `thr_sd <= thr_zf` is assumed.

The frame's symbol vectors are divided into equal contiguous blocks, one block for each parallel detector lane. Each lane walks through its own block with a start/done handshake, one vector at a time. A cycle counter measures the programmed per-packet decode budget. When every lane has finished before the budget runs out, the detector hardware is put to sleep for the rest of the window. When the budget runs out first, the frame is abandoned and a timeout is flagged. In both cases the sleep state lasts until the next frame start.

Top module: `detsel_ctrl`

## Requirements
- R1: At a frame start, a metric at or above `thr_zf` selects zero-forcing (`mode` = 2'b01). A metric below `thr_zf` and at or above `thr_sd` selects the sphere decoder (`mode` = 2'b10). A metric below `thr_sd` selects retransmission (`mode` = 2'b11). `mode` shows the choice from the cycle after the `frame_start` cycle.
- R2: Equality resolves toward the cheaper outcome. A metric equal to `thr_zf` gives zero-forcing, and a metric equal to `thr_sd` gives the sphere decoder.
- R3: For a retransmission frame, `arq_req` is high from the cycle after `frame_start` until the next frame start. No lane is started, `sleep_en` stays high, and any frame still in progress is abandoned.
- R4: The choice is latched at the frame start. Later changes on `metric` leave `mode` unchanged until the next `frame_start`.
- R5: Only the selected detector is used. Its start bits pulse and its done bits are listened to. Done bits of the other detector have no effect on sequencing.
- R6: With `NVEC/NLANES` = P, lane l handles vectors l*P to l*P+P-1 in ascending order, with one start pulse per vector. The first start comes the cycle after `frame_start`. Each later start comes the cycle after the done for the previous vector is sampled. `lane_vec` field l (bits l*VEC_W upward) carries the vector index while that lane's start is high.
- R7: `sleep_en` is high after reset. It drops in the cycle after a `frame_start` that selects a detector. It rises at the clock edge after the edge at which the last lane's final done is sampled.
- R8: Count the `frame_start` edge as edge 0. If the lanes have not all gone idle by edge `budget`, then `timeout` and `sleep_en` are set at that edge and the lanes stop. Completion seen at the same edge wins over the timeout. `timeout` is cleared by the next frame start.
- R9: After reset, `mode` is 2'b00, `arq_req` and `timeout` are low, and no start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| metric | input | MET_W | Channel-capacity metric of the frame |
| thr_zf | input | MET_W | Upper threshold (zero-forcing at or above) |
| thr_sd | input | MET_W | Lower threshold (sphere decoder at or above) |
| budget | input | BUD_W | Decode budget in clock cycles |
| zf_done | input | NLANES | Per-lane done from the zero-forcing detector |
| sd_done | input | NLANES | Per-lane done from the sphere decoder |
| zf_start | output | NLANES | Per-lane start to the zero-forcing detector |
| sd_start | output | NLANES | Per-lane start to the sphere decoder |
| lane_vec | output | NLANES*VEC_W | Vector index for each lane |
| mode | output | 2 | Latched choice (00 none, 01 ZF, 10 SD, 11 retransmit) |
| sleep_en | output | 1 | Detector sleep enable |
| arq_req | output | 1 | Retransmission request |
| timeout | output | 1 | Budget expired before completion |

## Verification
The bench builds the controller with 2 lanes, 8 vectors (4 per lane), a 6-bit metric and an 8-bit budget. With a 6-bit metric, every metric value can be swept against fixed thresholds, which covers both equality points and all three outcomes. With 4 vectors per lane and a one-cycle detector model, completion falls at edge 9. Budgets of 8 and 9 therefore sit exactly on the timeout-versus-completion boundary. A silent detector model exercises the plain timeout. The unselected detector's done lines are held high throughout, so any wrong routing would change when the frame completes.

// File: rtl/detsel_pkg.sv
package detsel_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_ZF   = 2'b01,
        SEL_SD   = 2'b10,
        SEL_ARQ  = 2'b11
    } sel_e;
endpackage

// File: rtl/detsel_classify.sv
module detsel_classify
    import detsel_pkg::*;
#(
    parameter int MET_W = 16
) (
    input  logic [MET_W-1:0] metric,
    input  logic [MET_W-1:0] thr_zf,
    input  logic [MET_W-1:0] thr_sd,
    output sel_e             choice
);
    // Ties resolve toward the cheaper detector.
    always_comb begin
        if (metric >= thr_zf)      choice = SEL_ZF;
        else if (metric >= thr_sd) choice = SEL_SD;
        else                       choice = SEL_ARQ;
    end
endmodule

// File: rtl/detsel_lane.sv
module detsel_lane #(
    parameter int PER   = 32,
    parameter int IDX_W = (PER > 1) ? $clog2(PER) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             abort,
    input  logic             done_in,
    output logic             start_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] vidx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PER - 1);

    typedef struct packed {
        logic             busy;
        logic             start;
        logic [IDX_W-1:0] vidx;
    } lane_s;

    lane_s q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (launch) begin
            d.busy  = 1'b1;
            d.start = 1'b1;
            d.vidx  = '0;
        end else if (abort) begin
            d.busy  = 1'b0;
        end else if (q.busy && done_in) begin
            if (q.vidx == LAST) begin
                d.busy  = 1'b0;
            end else begin
                d.vidx  = q.vidx + 1'b1;
                d.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o = q.start;
    assign busy_o  = q.busy;
    assign vidx_o  = q.vidx;

    // R6: the next vector follows a done on the one before it
    a_r6_vec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && done_in && q.vidx != LAST && !launch && !abort)
        |=> (start_o && vidx_o == $past(vidx_o) + 1'b1));

    // R6: the index never leaves the lane's block
    a_r6_vec_bound: assert property (@(posedge clk) disable iff (!rst_n)
        vidx_o <= LAST);
endmodule

// File: rtl/detsel_ctrl.sv
module detsel_ctrl
    import detsel_pkg::*;
#(
    parameter int MET_W  = 16,
    parameter int BUD_W  = 16,
    parameter int NLANES = 4,
    parameter int NVEC   = 128,
    parameter int PER    = NVEC / NLANES,
    parameter int VEC_W  = $clog2(NVEC),
    parameter int IDX_W  = (PER > 1) ? $clog2(PER) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic [MET_W-1:0]        metric,
    input  logic [MET_W-1:0]        thr_zf,
    input  logic [MET_W-1:0]        thr_sd,
    input  logic [BUD_W-1:0]        budget,
    input  logic [NLANES-1:0]       zf_done,
    input  logic [NLANES-1:0]       sd_done,
    output logic [NLANES-1:0]       zf_start,
    output logic [NLANES-1:0]       sd_start,
    output logic [NLANES*VEC_W-1:0] lane_vec,
    output logic [1:0]              mode,
    output logic                    sleep_en,
    output logic                    arq_req,
    output logic                    timeout
);
    typedef struct packed {
        sel_e             sel;
        logic             sleep;
        logic             arq;
        logic             tmo;
        logic             run;
        logic [BUD_W-1:0] cnt;
    } ctl_s;

    ctl_s q, d;
    sel_e choice;
    logic launch, lane_abort, all_idle;
    logic [NLANES-1:0] lane_busy, lane_start, lane_done;
    logic [IDX_W-1:0]  lane_vidx [NLANES];

    detsel_classify #(.MET_W(MET_W)) u_cls (
        .metric (metric),
        .thr_zf (thr_zf),
        .thr_sd (thr_sd),
        .choice (choice)
    );

    assign all_idle = (lane_busy == '0);
    assign launch   = frame_start && (choice != SEL_ARQ);

    always_comb begin
        d          = q;
        lane_abort = 1'b0;
        if (frame_start) begin
            d.sel      = choice;
            d.arq      = (choice == SEL_ARQ);
            d.sleep    = (choice == SEL_ARQ);
            d.run      = (choice != SEL_ARQ);
            d.tmo      = 1'b0;
            d.cnt      = '0;
            lane_abort = (choice == SEL_ARQ);
        end else if (q.run) begin
            if (all_idle) begin
                d.run   = 1'b0;
                d.sleep = 1'b1;
            end else if (({1'b0, q.cnt} + 1'b1) >= {1'b0, budget}) begin
                d.run      = 1'b0;
                d.sleep    = 1'b1;
                d.tmo      = 1'b1;
                lane_abort = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sel   <= SEL_NONE;
            q.sleep <= 1'b1;
        end else begin
            q <= d;
        end
    end

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        assign lane_done[l] = (q.sel == SEL_ZF) ? zf_done[l] :
                              (q.sel == SEL_SD) ? sd_done[l] : 1'b0;

        detsel_lane #(.PER(PER), .IDX_W(IDX_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .launch  (launch),
            .abort   (lane_abort),
            .done_in (lane_done[l]),
            .start_o (lane_start[l]),
            .busy_o  (lane_busy[l]),
            .vidx_o  (lane_vidx[l])
        );

        assign lane_vec[l*VEC_W +: VEC_W] = VEC_W'(l * PER) + VEC_W'(lane_vidx[l]);
    end

    assign zf_start = lane_start & {NLANES{q.sel == SEL_ZF}};
    assign sd_start = lane_start & {NLANES{q.sel == SEL_SD}};
    assign mode     = q.sel;
    assign sleep_en = q.sleep;
    assign arq_req  = q.arq;
    assign timeout  = q.tmo;

    // R7: a detecting frame wakes the hardware on the next cycle
    a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && choice != SEL_ARQ) |=> !sleep_en);

    // R4: the choice holds between frame starts
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode));

    // R3: no lane is active while a retransmission is requested
    a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
        arq_req |-> (lane_busy == '0));

    // R8: a timeout always comes with sleep
    a_r8_tmo_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> sleep_en);

    // R5: never both detectors at once
    a_r5_one_det: assert property (@(posedge clk) disable iff (!rst_n)
        !((|zf_start) && (|sd_start)));
endmodule

// File: tb/detsel_ctrl_test.sv
module detsel_ctrl_test;
    localparam int TCLK = 10;
    localparam int NL = 2, NV = 8, PER = NV / NL, VW = 3, MW = 6, BW = 8;

    logic clk = 0, rst_n = 0, frame_start = 0;
    logic [MW-1:0] metric = 0, thr_zf = 40, thr_sd = 20;
    logic [BW-1:0] budget = 20;
    logic [NL-1:0] zf_done = 0, sd_done = 0, zf_start, sd_start;
    logic [NL*VW-1:0] lane_vec;
    logic [1:0] mode;
    logic sleep_en, arq_req, timeout;

    int nchk = 0, nfail = 0;
    int cur_sel = 0;
    bit resp_en = 1;
    int seen [NL];

    always #(TCLK/2) clk = ~clk;

    detsel_ctrl #(.MET_W(MW), .BUD_W(BW), .NLANES(NL), .NVEC(NV)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .metric(metric),
        .thr_zf(thr_zf), .thr_sd(thr_sd), .budget(budget),
        .zf_done(zf_done), .sd_done(sd_done), .zf_start(zf_start),
        .sd_start(sd_start), .lane_vec(lane_vec), .mode(mode),
        .sleep_en(sleep_en), .arq_req(arq_req), .timeout(timeout));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Detector model: selected one answers one cycle after start; the other one
    // holds done high (R5).
    always @(posedge clk) begin
        for (int l = 0; l < NL; l++) begin
            zf_done[l] <= (cur_sel == 1) ? (resp_en & zf_start[l]) : 1'b1;
            sd_done[l] <= (cur_sel == 2) ? (resp_en & sd_start[l]) : 1'b1;
        end
    end

    // R6/R5 start monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < NL; l++) begin
                if (zf_start[l] || sd_start[l]) begin
                    chk((zf_start[l] && cur_sel == 1) || (sd_start[l] && cur_sel == 2),
                        "R5 start on selected detector", int'(sd_start[l]), int'(cur_sel == 2));
                    chk(int'(lane_vec[l*VW +: VW]) == l*PER + seen[l], "R6 lane vector index",
                        int'(lane_vec[l*VW +: VW]), l*PER + seen[l]);
                    seen[l]++;
                end
            end
        end
    end

    function automatic int exp_sel(input int m);
        if (m >= int'(thr_zf)) return 1;
        if (m >= int'(thr_sd)) return 2;
        return 3;
    endfunction

    task automatic run_frame(input int m, input int bud, input bit resp);
        int es, ek, k;
        bit et;
        es = exp_sel(m);
        @(negedge clk);
        metric = MW'(m); budget = BW'(bud); frame_start = 1;
        cur_sel = es; resp_en = resp;
        for (int l = 0; l < NL; l++) seen[l] = 0;
        @(negedge clk);
        frame_start = 0;
        metric = MW'(63 - m);
        chk(int'(mode) == es, "R1 mode choice", int'(mode), es);
        chk(arq_req == (es == 3), "R3 arq_req", int'(arq_req), int'(es == 3));
        chk(sleep_en == (es == 3), "R7 sleep after frame start", int'(sleep_en), int'(es == 3));
        chk(timeout == 0, "R8 timeout cleared", int'(timeout), 0);
        if (es == 3) begin
            repeat (6) begin
                @(negedge clk);
                chk(sleep_en && arq_req, "R3 arq held with sleep", int'(sleep_en & arq_req), 1);
            end
            chk(seen[0] + seen[1] == 0, "R3 no start", seen[0] + seen[1], 0);
        end else begin
            ek = 2*PER + 1; et = 0;
            if (!resp || bud < ek) begin ek = bud; et = 1; end
            k = 0;
            for (int i = 1; i <= 60; i++) begin
                @(negedge clk);
                if (sleep_en) begin k = i; break; end
            end
            chk(k == ek, "R7/R8 sleep edge", k, ek);
            chk(timeout == et, "R8 timeout flag", int'(timeout), int'(et));
            chk(int'(mode) == es, "R4 mode held", int'(mode), es);
            if (!et)
                for (int l = 0; l < NL; l++)
                    chk(seen[l] == PER, "R6 starts per lane", seen[l], PER);
            repeat (2) @(negedge clk);
            chk(seen[0] + seen[1] == (et ? seen[0] + seen[1] : 2*PER), "R8 lanes quiet", seen[0] + seen[1], 2*PER);
        end
    endtask

    initial begin
        #(TCLK * 150000);
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) seen[l] = 0;
        repeat (3) @(negedge clk);
        chk(int'(mode) == 0, "R9 reset mode", int'(mode), 0);
        chk(sleep_en == 1, "R9/R7 reset sleep", int'(sleep_en), 1);
        chk(!arq_req && !timeout, "R9 reset flags", int'(arq_req | timeout), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(zf_start == 0 && sd_start == 0, "R9 no start", int'(zf_start | sd_start), 0);

        // R1/R2: full metric sweep, includes 40 (=thr_zf) and 20 (=thr_sd)
        for (int m = 0; m < 64; m++) run_frame(m, 20, 1);
        // R2: explicit tie points with distinct thresholds
        thr_zf = 33; thr_sd = 32;
        run_frame(33, 20, 1);
        run_frame(32, 20, 1);
        run_frame(31, 20, 1);
        thr_zf = 40; thr_sd = 20;
        // R8: boundary around completion at edge 9
        run_frame(50, 8, 1);
        run_frame(50, 9, 1);
        run_frame(30, 9, 1);
        // R8: silent detector
        run_frame(30, 5, 0);
        run_frame(10, 20, 1);
        run_frame(45, 3, 0);
        run_frame(25, 20, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule